// File: doc/BRIEF.md
# Burst Read Data Pipeline

This block is the device-side read return path of a double-data-rate graphics memory, written at the level of whole clock cycles. Each clock it samples one command (idle, read or burst stop) together with a column address. A read starts a four-beat burst that appears on the modelled data outputs once the selected CAS latency has passed. Each clock carries two beat slots, one for the rising half and one for the falling half, so a burst fills two consecutive clocks. A strobe pair is driven alongside the data.

A later read cuts short a burst that is still in flight. The old burst keeps its slots until the new command's latency has passed, and then the new data takes over. A burst stop ends the current burst one CAS latency after it is sampled and releases the bus. Beat data is the burst's start column plus the beat index, so any observer can predict every slot. The released (high-impedance) state is shown by the output-enable flags. While released, the data and strobe pins read as zero.

Top module: `rbp_read_path`

## Requirements
- R1: While reset is held and after it is released with no command, `dq_oe` and `dqs_oe` are 0 and `dq_even`, `dq_odd` and `dqs` are all zero.
- R2: Command encoding on `cmd`: 2'b00 idle, 2'b01 read, 2'b10 burst stop. Code 2'b11 is treated as idle and changes no output.
- R3: `cl_sel` picks the CAS latency: 0 gives 2 clocks, 1 gives 3, 2 and 3 give 4. A read sampled at rising edge k shows its first beat pair in the cycle after edge k+CL, and the cycle after edge k+CL-1 is still released.
- R4: A burst covers two consecutive cycles. In the first, `dq_even` = col and `dq_odd` = col+1. In the second, they are col+2 and col+3. The column is zero-extended to the data width before the beat index is added.
- R5: Whenever data is driven, `dqs_oe` = 1 and `dqs` = 2'b01 (bit 0 is the rising-slot level, high; bit 1 is the falling-slot level, low). Otherwise `dqs_oe` = 0 and `dqs` = 0.
- R6: A read whose latency has passed replaces what remains of the earlier burst. With two reads one clock apart, the bus shows the first burst's first pair and then all four beats of the second burst.
- R7: A burst stop sampled at edge k releases the bus from the cycle after edge k+CL. Beats of the interrupted burst not yet shown are dropped, and a later read is served normally.
- R8: A burst stop issued with no burst in flight, or after a burst has already completed, has no effect on the outputs or on later reads.
- R9: In every released cycle, `dq_even` and `dq_odd` are zero.
- R10: Two reads spaced exactly two clocks apart produce eight beats in four back-to-back cycles with no released cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 2 | Command code sampled every clock |
| col | input | COL_W | Burst start column, sampled with a read |
| cl_sel | input | 2 | CAS latency select |
| dq_even | output | DATA_W | Rising-slot beat |
| dq_odd | output | DATA_W | Falling-slot beat |
| dq_oe | output | 1 | Data outputs driven (0 = high impedance) |
| dqs | output | 2 | Strobe levels for the rising and falling slots |
| dqs_oe | output | 1 | Strobe driven (0 = high impedance) |

## Verification
The bound checker runs on every cycle. It checks the relation between a due command at the delay-line tap and the next output cycle: a read loads its first pair, a stop releases the bus, and the pending second half follows the first by two beats. It also checks that the odd slot always sits one above the even slot, that the strobe tracks the data enable, that released cycles carry zeros, and that nothing is driven without a due read or a pending tail. The exact cycle counts for each latency setting, the truncation points under interrupting reads and stops, and the encoding of the reserved command can only be shown by the bench's scenarios, which compare full cycle traces against hand-computed expectations.

// File: rtl/rbp_pkg.sv
package rbp_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'b00,
    CMD_READ = 2'b01,
    CMD_STOP = 2'b10,
    CMD_RSVD = 2'b11
  } rbp_cmd_e;

  // Latency select to clock count: 0->2, 1->3, 2/3->4
  function automatic logic [2:0] cl_from_sel(input logic [1:0] sel);
    logic [2:0] cl;
    case (sel)
      2'd0:    cl = 3'd2;
      2'd1:    cl = 3'd3;
      default: cl = 3'd4;
    endcase
    return cl;
  endfunction

  // Beat word: zero-extended start column plus beat index
  function automatic logic [31:0] beat_sum(input logic [31:0] start_col,
                                           input logic [1:0]  idx);
    return start_col + 32'(idx);
  endfunction

endpackage

// File: rtl/rbp_cmd_delay.sv
module rbp_cmd_delay #(
  parameter int COL_W = 10,
  parameter int DEPTH = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_read,
  input  logic             in_stop,
  input  logic [COL_W-1:0] in_col,
  input  logic [IDX_W-1:0] tap_idx,
  output logic             tap_read,
  output logic             tap_stop,
  output logic [COL_W-1:0] tap_col
);

  logic [DEPTH-1:0] rd_q;
  logic [DEPTH-1:0] st_q;
  logic [COL_W-1:0] col_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rd_q[g]  <= 1'b0;
          st_q[g]  <= 1'b0;
          col_q[g] <= '0;
        end else begin
          rd_q[g]  <= in_read;
          st_q[g]  <= in_stop;
          col_q[g] <= in_col;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rd_q[g]  <= 1'b0;
          st_q[g]  <= 1'b0;
          col_q[g] <= '0;
        end else begin
          rd_q[g]  <= rd_q[g-1];
          st_q[g]  <= st_q[g-1];
          col_q[g] <= col_q[g-1];
        end
      end
    end
  end

  always_comb begin
    tap_read = rd_q[tap_idx];
    tap_stop = st_q[tap_idx];
    tap_col  = col_q[tap_idx];
  end

endmodule

// File: rtl/rbp_burst_seq.sv
module rbp_burst_seq #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tap_read,
  input  logic             tap_stop,
  input  logic [COL_W-1:0] tap_col,
  output logic             drive_on,
  output logic             drive_half,
  output logic [COL_W-1:0] drive_col,
  output logic             tail_due
);

  logic             on_q;
  logic             half_q;
  logic [COL_W-1:0] col_q;

  // The first pair is on the bus now, so the second pair is owed next cycle
  assign tail_due = on_q && !half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      half_q <= 1'b0;
      col_q  <= '0;
    end else if (tap_read) begin
      on_q   <= 1'b1;
      half_q <= 1'b0;
      col_q  <= tap_col;
    end else if (tap_stop) begin
      on_q   <= 1'b0;
      half_q <= 1'b0;
    end else if (tail_due) begin
      on_q   <= 1'b1;
      half_q <= 1'b1;
    end else begin
      on_q   <= 1'b0;
      half_q <= 1'b0;
    end
  end

  assign drive_on   = on_q;
  assign drive_half = half_q;
  assign drive_col  = col_q;

endmodule

// File: rtl/rbp_beat_gen.sv
module rbp_beat_gen #(
  parameter int COL_W  = 10,
  parameter int DATA_W = 16
) (
  input  logic              drive_on,
  input  logic              drive_half,
  input  logic [COL_W-1:0]  drive_col,
  output logic [DATA_W-1:0] dq_even,
  output logic [DATA_W-1:0] dq_odd,
  output logic              dq_oe,
  output logic [1:0]        dqs,
  output logic              dqs_oe
);
  import rbp_pkg::*;

  logic [31:0] col_ext;
  logic [1:0]  idx_even;
  logic [1:0]  idx_odd;

  assign col_ext  = 32'(drive_col);
  assign idx_even = {drive_half, 1'b0};
  assign idx_odd  = {drive_half, 1'b1};

  always_comb begin
    if (drive_on) begin
      dq_even = DATA_W'(beat_sum(col_ext, idx_even));
      dq_odd  = DATA_W'(beat_sum(col_ext, idx_odd));
      dqs     = 2'b01;
    end else begin
      dq_even = '0;
      dq_odd  = '0;
      dqs     = 2'b00;
    end
    dq_oe  = drive_on;
    dqs_oe = drive_on;
  end

endmodule

// File: rtl/rbp_read_path.sv
module rbp_read_path #(
  parameter int COL_W  = 10,
  parameter int DATA_W = 16,
  parameter int MAX_CL = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd,
  input  logic [COL_W-1:0]  col,
  input  logic [1:0]        cl_sel,
  output logic [DATA_W-1:0] dq_even,
  output logic [DATA_W-1:0] dq_odd,
  output logic              dq_oe,
  output logic [1:0]        dqs,
  output logic              dqs_oe
);
  import rbp_pkg::*;

  localparam int IDX_W = (MAX_CL > 1) ? $clog2(MAX_CL) : 1;

  logic             cmd_read;
  logic             cmd_stop;
  logic [2:0]       cl_clocks;
  logic [IDX_W-1:0] tap_idx;
  logic             tap_read;
  logic             tap_stop;
  logic [COL_W-1:0] tap_col;
  logic             drive_on;
  logic             drive_half;
  logic [COL_W-1:0] drive_col;
  logic             tail_due;

  assign cmd_read  = (rbp_cmd_e'(cmd) == CMD_READ);
  assign cmd_stop  = (rbp_cmd_e'(cmd) == CMD_STOP);
  assign cl_clocks = cl_from_sel(cl_sel);
  assign tap_idx   = IDX_W'(cl_clocks - 3'd1);

  rbp_cmd_delay #(.COL_W(COL_W), .DEPTH(MAX_CL)) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_read  (cmd_read),
    .in_stop  (cmd_stop),
    .in_col   (col),
    .tap_idx  (tap_idx),
    .tap_read (tap_read),
    .tap_stop (tap_stop),
    .tap_col  (tap_col)
  );

  rbp_burst_seq #(.COL_W(COL_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tap_read   (tap_read),
    .tap_stop   (tap_stop),
    .tap_col    (tap_col),
    .drive_on   (drive_on),
    .drive_half (drive_half),
    .drive_col  (drive_col),
    .tail_due   (tail_due)
  );

  rbp_beat_gen #(.COL_W(COL_W), .DATA_W(DATA_W)) u_beat (
    .drive_on   (drive_on),
    .drive_half (drive_half),
    .drive_col  (drive_col),
    .dq_even    (dq_even),
    .dq_odd     (dq_odd),
    .dq_oe      (dq_oe),
    .dqs        (dqs),
    .dqs_oe     (dqs_oe)
  );

endmodule

// File: rtl/rbp_read_path_chk.sv
module rbp_read_path_chk #(
  parameter int COL_W  = 10,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tap_read,
  input logic              tap_stop,
  input logic [COL_W-1:0]  tap_col,
  input logic              tail_due,
  input logic [DATA_W-1:0] dq_even,
  input logic [DATA_W-1:0] dq_odd,
  input logic              dq_oe,
  input logic [1:0]        dqs,
  input logic              dqs_oe
);
  import rbp_pkg::*;

  // R7: a due stop with no due read releases the bus next cycle
  p_stop_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_stop && !tap_read) |=> !dq_oe);

  // R4, R6: a due read puts its first pair on the bus next cycle
  p_read_first_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tap_read |=> (dq_oe && dq_even == DATA_W'(beat_sum(32'($past(tap_col)), 2'd0))));

  // R4: the second pair follows the first, two beats higher
  p_tail_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_due && !tap_read && !tap_stop) |=> (dq_oe && dq_even == $past(dq_even) + DATA_W'(2)));

  // R4: the falling slot is always one beat above the rising slot
  p_pair_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (dq_odd == dq_even + DATA_W'(1)));

  // R5: strobe driven with the data, with fixed slot levels
  p_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (dqs_oe && dqs == 2'b01));

  // R5, R9: released cycles carry zeros and no strobe
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (!dqs_oe && dqs == 2'b00 && dq_even == '0 && dq_odd == '0));

  // R8: nothing is driven unless a read is due or a tail is owed
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tap_read && !tail_due) |=> !dq_oe);

endmodule

bind rbp_read_path rbp_read_path_chk #(.COL_W(COL_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tap_read (tap_read),
  .tap_stop (tap_stop),
  .tap_col  (tap_col),
  .tail_due (tail_due),
  .dq_even  (dq_even),
  .dq_odd   (dq_odd),
  .dq_oe    (dq_oe),
  .dqs      (dqs),
  .dqs_oe   (dqs_oe)
);

// File: tb/rbp_read_path_tb.sv
module rbp_read_path_tb;

  localparam int COL_W  = 10;
  localparam int DATA_W = 16;
  localparam int NSLOT  = 24;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        cmd = 2'b00;
  logic [COL_W-1:0]  col = '0;
  logic [1:0]        cl_sel = 2'd0;
  logic [DATA_W-1:0] dq_even;
  logic [DATA_W-1:0] dq_odd;
  logic              dq_oe;
  logic [1:0]        dqs;
  logic              dqs_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [1:0]        seq_cmd [NSLOT];
  logic [COL_W-1:0]  seq_col [NSLOT];
  logic              obs_oe  [NSLOT];
  logic [DATA_W-1:0] obs_ev  [NSLOT];
  logic [DATA_W-1:0] obs_od  [NSLOT];
  logic [1:0]        obs_dqs [NSLOT];
  logic              obs_soe [NSLOT];

  always #10 clk = ~clk;

  rbp_read_path #(.COL_W(COL_W), .DATA_W(DATA_W), .MAX_CL(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .col(col), .cl_sel(cl_sel),
    .dq_even(dq_even), .dq_odd(dq_odd), .dq_oe(dq_oe), .dqs(dqs), .dqs_oe(dqs_oe)
  );

  task automatic clear_seq();
    for (int i = 0; i < NSLOT; i++) begin
      seq_cmd[i] = 2'b00;
      seq_col[i] = '0;
    end
  endtask

  // Command i is sampled at edge i; obs[t] is the state after edge t
  task automatic run_seq();
    for (int i = 0; i <= NSLOT; i++) begin
      @(negedge clk);
      if (i > 0) begin
        obs_oe[i-1]  = dq_oe;
        obs_ev[i-1]  = dq_even;
        obs_od[i-1]  = dq_odd;
        obs_dqs[i-1] = dqs;
        obs_soe[i-1] = dqs_oe;
      end
      cmd = (i < NSLOT) ? seq_cmd[i] : 2'b00;
      col = (i < NSLOT) ? seq_col[i] : '0;
    end
  endtask

  task automatic expect_slot(input string req, input int t, input bit e_oe,
                             input logic [DATA_W-1:0] e_ev);
    logic [DATA_W-1:0] e_od;
    logic [1:0]        e_dqs;
    e_od  = e_oe ? e_ev + DATA_W'(1) : '0;
    e_dqs = e_oe ? 2'b01 : 2'b00;
    if (!e_oe) e_ev = '0;
    checks++;
    if (obs_oe[t] !== e_oe || obs_ev[t] !== e_ev || obs_od[t] !== e_od ||
        obs_dqs[t] !== e_dqs || obs_soe[t] !== e_oe) begin
      errors++;
      $display("FAIL %s slot %0d: oe=%0b even=%h odd=%h dqs=%b dqs_oe=%0b expected oe=%0b even=%h odd=%h dqs=%b dqs_oe=%0b",
               req, t, obs_oe[t], obs_ev[t], obs_od[t], obs_dqs[t], obs_soe[t],
               e_oe, e_ev, e_od, e_dqs, e_oe);
    end
  endtask

  task automatic t_reset();
    // R1, R9: released and zero after reset
    @(negedge clk);
    obs_oe[0] = dq_oe; obs_ev[0] = dq_even; obs_od[0] = dq_odd;
    obs_dqs[0] = dqs; obs_soe[0] = dqs_oe;
    expect_slot("R1", 0, 1'b0, '0);
  endtask

  task automatic t_basic_cl2();
    // R3, R4, R5: CL=2, col 0x010
    cl_sel = 2'd0; clear_seq();
    seq_cmd[1] = 2'b01; seq_col[1] = 10'h010;
    run_seq();
    expect_slot("R3", 2, 1'b0, '0);
    expect_slot("R3", 3, 1'b1, 16'h0010);
    expect_slot("R4", 4, 1'b1, 16'h0012);
    expect_slot("R5", 5, 1'b0, '0);
  endtask

  task automatic t_cl3_top_col();
    // R3, R4: CL=3 with column at its top value; sum zero-extends
    cl_sel = 2'd1; clear_seq();
    seq_cmd[1] = 2'b01; seq_col[1] = 10'h3FF;
    run_seq();
    expect_slot("R3", 3, 1'b0, '0);
    expect_slot("R3", 4, 1'b1, 16'h03FF);
    expect_slot("R4", 5, 1'b1, 16'h0401);
    expect_slot("R4", 6, 1'b0, '0);
  endtask

  task automatic t_cl4(input logic [1:0] sel);
    // R3: selects 2 and 3 both give CL=4
    cl_sel = sel; clear_seq();
    seq_cmd[1] = 2'b01; seq_col[1] = 10'h100;
    run_seq();
    expect_slot("R3", 4, 1'b0, '0);
    expect_slot("R3", 5, 1'b1, 16'h0100);
    expect_slot("R4", 6, 1'b1, 16'h0102);
    expect_slot("R9", 7, 1'b0, '0);
  endtask

  task automatic t_interrupt_ccd1();
    // R6: reads one clock apart, CL=2
    cl_sel = 2'd0; clear_seq();
    seq_cmd[1] = 2'b01; seq_col[1] = 10'h020;
    seq_cmd[2] = 2'b01; seq_col[2] = 10'h040;
    run_seq();
    expect_slot("R6", 3, 1'b1, 16'h0020);
    expect_slot("R6", 4, 1'b1, 16'h0040);
    expect_slot("R6", 5, 1'b1, 16'h0042);
    expect_slot("R6", 6, 1'b0, '0);
  endtask

  task automatic t_seamless();
    // R10: reads two clocks apart, CL=3
    cl_sel = 2'd1; clear_seq();
    seq_cmd[1] = 2'b01; seq_col[1] = 10'h050;
    seq_cmd[3] = 2'b01; seq_col[3] = 10'h060;
    run_seq();
    expect_slot("R10", 4, 1'b1, 16'h0050);
    expect_slot("R10", 5, 1'b1, 16'h0052);
    expect_slot("R10", 6, 1'b1, 16'h0060);
    expect_slot("R10", 7, 1'b1, 16'h0062);
    expect_slot("R10", 8, 1'b0, '0);
  endtask

  task automatic t_stop(input logic [1:0] sel, input int cl);
    // R7: stop one clock after the read; then a read after the stop
    cl_sel = sel; clear_seq();
    seq_cmd[1] = 2'b01; seq_col[1] = 10'h070;
    seq_cmd[2] = 2'b10; seq_col[2] = 10'h155;
    seq_cmd[3] = 2'b01; seq_col[3] = 10'h090;
    run_seq();
    expect_slot("R7", 1 + cl, 1'b1, 16'h0070);
    expect_slot("R7", 2 + cl, 1'b0, '0);
    expect_slot("R7", 3 + cl, 1'b1, 16'h0090);
    expect_slot("R7", 4 + cl, 1'b1, 16'h0092);
    expect_slot("R7", 5 + cl, 1'b0, '0);
  endtask

  task automatic t_stop_idle();
    // R8: stop with nothing in flight, and stop after a completed burst
    cl_sel = 2'd0; clear_seq();
    seq_cmd[1] = 2'b10;
    seq_cmd[5] = 2'b01; seq_col[5] = 10'h0A0;
    seq_cmd[9] = 2'b10;
    seq_cmd[11] = 2'b01; seq_col[11] = 10'h0B0;
    run_seq();
    expect_slot("R8", 3, 1'b0, '0);
    expect_slot("R8", 7, 1'b1, 16'h00A0);
    expect_slot("R8", 8, 1'b1, 16'h00A2);
    expect_slot("R8", 11, 1'b0, '0);
    expect_slot("R8", 13, 1'b1, 16'h00B0);
    expect_slot("R8", 14, 1'b1, 16'h00B2);
  endtask

  task automatic t_rsvd_code();
    // R2: code 2'b11 acts as idle
    cl_sel = 2'd0; clear_seq();
    seq_cmd[1] = 2'b01; seq_col[1] = 10'h080;
    seq_cmd[2] = 2'b11; seq_col[2] = 10'h0C0;
    seq_cmd[6] = 2'b11; seq_col[6] = 10'h0D0;
    run_seq();
    expect_slot("R2", 3, 1'b1, 16'h0080);
    expect_slot("R2", 4, 1'b1, 16'h0082);
    expect_slot("R2", 5, 1'b0, '0);
    expect_slot("R2", 8, 1'b0, '0);
    expect_slot("R2", 9, 1'b0, '0);
  endtask

  initial begin : watchdog
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_seq();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic_cl2();
    t_cl3_top_col();
    t_cl4(2'd2);
    t_cl4(2'd3);
    t_interrupt_ccd1();
    t_seamless();
    t_stop(2'd0, 2);
    t_stop(2'd2, 4);
    t_stop_idle();
    t_rsvd_code();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule